// File: doc/BRIEF.md
# Load/Store Instruction Execution Unit

This block executes the data-move part of a compact 32-bit RISC instruction set with fixed 16-bit encodings. Each cycle it can accept one instruction word together with the current program-counter value. It holds sixteen 32-bit general registers. It decodes the move form, forms the effective address and drives a single memory access. At the next rising clock edge it commits every register change the instruction causes: the loaded or moved value, and any pre-decrement or post-increment of an address register.

The memory port works in the same cycle. Address, size code, write data and the read and write enables follow the presented instruction through combinational logic. The memory returns read data in the same cycle, with the addressed item right-aligned in the low bits. Byte and word loads are sign-extended from bit 7 or bit 15 of the read data. Byte and word stores carry only the low 8 or 16 bits of the source register, zero-padded above.

The displacement is scaled by the access size. The register R0 acts either as an index added to a base register or as the implied data register of the short displacement forms. Any word outside the supported set is flagged as illegal and has no effect.

Top module: `lsu_exec`

## Requirements
- R1: `1110 nnnn iiii iiii` writes the 8-bit immediate, sign-extended to 32 bits, into register n. It makes no memory access.
- R2: `1001 nnnn dddd dddd` reads a word (size 01) at pc_in + d×2 and writes it into register n, sign-extended from bit 15. `1101 nnnn dddd dddd` reads a long (size 10) at pc_in + d×4 into register n. In both forms d is an unsigned 8-bit value.
- R3: `0110 nnnn mmmm 00ss` with ss = 00, 01 or 10 reads a byte, word or long at the address in register m into register n. Byte and word data are sign-extended. `0110 nnnn mmmm 0011` copies register m into register n without a memory access.
- R4: `0010 nnnn mmmm 00ss` stores register m at the address in register n. `0010 nnnn mmmm 01ss` first subtracts 1, 2 or 4 (for ss = 00, 01, 10) from register n, stores at the reduced address, and leaves register n holding that address.
- R5: `0110 nnnn mmmm 01ss` reads at the address in register m into register n, then adds 1, 2 or 4 to register m. When n equals m, register n ends up holding the loaded value.
- R6: `1000 0000 nnnn dddd` and `1000 0001 nnnn dddd` store R0 as a byte at Rn + d or as a word at Rn + d×2. `1000 0100 mmmm dddd` and `1000 0101 mmmm dddd` load a sign-extended byte from Rm + d or word from Rm + d×2 into R0. Here d is 4-bit unsigned.
- R7: `0001 nnnn mmmm dddd` stores register m as a long at Rn + d×4. `0101 nnnn mmmm dddd` loads a long from Rm + d×4 into register n.
- R8: `0000 nnnn mmmm 0100` and `0000 nnnn mmmm 0101` store register m as a byte or word at R0 + Rn.
- R9: mem_size is 00 for byte, 01 for word and 10 for long. Byte and word stores drive the low 8 or 16 bits of the source with zeros above. mem_we is high only for stores, mem_re only for loads, and the two are never high together.
- R10: Any valid word not listed in R1–R8 (for example `0xFFFF`, suffix `0111` under `0010` or `0110`, `1000 0010 ...`, `0000 nnnn mmmm 0110`) raises illegal in that cycle. It drives neither enable and changes no register.
- R11: While instr_valid is low, no memory enable or illegal flag is driven and no register changes.
- R12: A synchronous active-high reset clears all sixteen registers to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register updates commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word below is to be executed this cycle |
| instr | input | 16 | Instruction word |
| pc_in | input | 32 | Program-counter value for PC-relative loads |
| mem_addr | output | 32 | Effective byte address of the access |
| mem_size | output | 2 | Access size: 00 byte, 01 word, 10 long |
| mem_re | output | 1 | Read access this cycle |
| mem_we | output | 1 | Write access this cycle |
| mem_wdata | output | 32 | Store data, right-aligned and zero-padded |
| mem_rdata | input | 32 | Read data, item right-aligned, same cycle |
| illegal | output | 1 | Presented valid word is outside the supported set |

## Verification
A wrong register value stays hidden until some later instruction uses that register. It then shows up as a wrong mem_addr when the register serves as a base or index, or as wrong mem_wdata when it is stored. The bench therefore follows every load, copy, decrement and increment with a store that exposes the affected register within one or two instructions. An illegal word that wrongly changed a register would surface only at that later store. A wrong decode shows up in the same cycle as a wrong size code, enable or address.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int INSN_W = 16;
  localparam int RIDX_W = 4;
  localparam int DISP_W = 8;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2} size_e;
  typedef enum logic [2:0] {K_NONE, K_IMM, K_COPY, K_LOAD, K_STORE} kind_e;
  typedef enum logic [1:0] {B_PC, B_REG, B_IDX} base_e;

  typedef struct packed {
    logic              legal;
    kind_e             kind;
    size_e             size;
    base_e             base;
    logic [RIDX_W-1:0] base_idx;
    logic [RIDX_W-1:0] data_idx;
    logic [RIDX_W-1:0] dst_idx;
    logic [DISP_W-1:0] disp;
    logic              predec;
    logic              postinc;
  } dec_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output dec_t              dec
);
  logic [3:0] op, f_hi, f_mid, f_lo;
  assign op    = instr[15:12];
  assign f_hi  = instr[11:8];
  assign f_mid = instr[7:4];
  assign f_lo  = instr[3:0];

  always_comb begin
    dec = '0;
    dec.kind = K_NONE;
    dec.size = SZ_L;
    dec.base = B_REG;
    unique case (op)
      4'hE: begin
        dec.legal = 1'b1; dec.kind = K_IMM; dec.dst_idx = f_hi;
      end
      4'h9, 4'hD: begin
        dec.legal = 1'b1; dec.kind = K_LOAD; dec.base = B_PC;
        dec.size = (op == 4'h9) ? SZ_W : SZ_L;
        dec.dst_idx = f_hi; dec.disp = instr[7:0];
      end
      4'h6: begin
        dec.dst_idx = f_hi; dec.base_idx = f_mid; dec.data_idx = f_mid;
        case (f_lo)
          4'h0, 4'h1, 4'h2: begin
            dec.legal = 1'b1; dec.kind = K_LOAD; dec.size = size_e'(f_lo[1:0]);
          end
          4'h3: begin
            dec.legal = 1'b1; dec.kind = K_COPY;
          end
          4'h4, 4'h5, 4'h6: begin
            dec.legal = 1'b1; dec.kind = K_LOAD; dec.size = size_e'(f_lo[1:0]);
            dec.postinc = 1'b1;
          end
          default: dec.legal = 1'b0;
        endcase
      end
      4'h2: begin
        dec.base_idx = f_hi; dec.data_idx = f_mid;
        case (f_lo)
          4'h0, 4'h1, 4'h2: begin
            dec.legal = 1'b1; dec.kind = K_STORE; dec.size = size_e'(f_lo[1:0]);
          end
          4'h4, 4'h5, 4'h6: begin
            dec.legal = 1'b1; dec.kind = K_STORE; dec.size = size_e'(f_lo[1:0]);
            dec.predec = 1'b1;
          end
          default: dec.legal = 1'b0;
        endcase
      end
      4'h8: begin
        dec.base_idx = f_mid; dec.disp = {4'h0, f_lo};
        case (f_hi)
          4'h0, 4'h1: begin
            dec.legal = 1'b1; dec.kind = K_STORE; dec.size = size_e'(f_hi[1:0]);
            dec.data_idx = '0;
          end
          4'h4, 4'h5: begin
            dec.legal = 1'b1; dec.kind = K_LOAD; dec.size = size_e'(f_hi[1:0]);
            dec.dst_idx = '0;
          end
          default: dec.legal = 1'b0;
        endcase
      end
      4'h1: begin
        dec.legal = 1'b1; dec.kind = K_STORE; dec.size = SZ_L;
        dec.base_idx = f_hi; dec.data_idx = f_mid; dec.disp = {4'h0, f_lo};
      end
      4'h5: begin
        dec.legal = 1'b1; dec.kind = K_LOAD; dec.size = SZ_L;
        dec.base_idx = f_mid; dec.dst_idx = f_hi; dec.disp = {4'h0, f_lo};
      end
      4'h0: begin
        dec.base = B_IDX; dec.base_idx = f_hi; dec.data_idx = f_mid;
        if (f_lo == 4'h4 || f_lo == 4'h5) begin
          dec.legal = 1'b1; dec.kind = K_STORE; dec.size = size_e'(f_lo[1:0]);
        end
      end
      default: dec.legal = 1'b0;
    endcase
    if (!dec.legal) begin
      dec.kind = K_NONE; dec.predec = 1'b0; dec.postinc = 1'b0;
    end
  end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  base_e             base,
  input  size_e             size,
  input  logic [DISP_W-1:0] disp,
  input  logic              predec,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] rbase,
  input  logic [DATA_W-1:0] r0,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] upd
);
  logic [DATA_W-1:0] step, scaled, origin, dec_val;

  assign step    = DATA_W'(1) << size;
  assign scaled  = DATA_W'(disp) << size;
  assign dec_val = rbase - step;

  always_comb begin
    unique case (base)
      B_PC:    origin = pc;
      B_IDX:   origin = rbase + r0;
      default: origin = rbase;
    endcase
  end

  assign addr = predec ? dec_val : origin + scaled;
  assign upd  = predec ? dec_val : rbase + step;
endmodule

// File: rtl/lsu_regfile.sv
module lsu_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     ra_a,
  input  logic [AW-1:0]     ra_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic [DATA_W-1:0] rd_r0,
  input  logic              wen_p,
  input  logic [AW-1:0]     wa_p,
  input  logic [DATA_W-1:0] wd_p,
  input  logic              wen_s,
  input  logic [AW-1:0]     wa_s,
  input  logic [DATA_W-1:0] wd_s
);
  logic [NREGS-1:0][DATA_W-1:0] regs;

  assign rd_a  = regs[ra_a];
  assign rd_b  = regs[ra_b];
  assign rd_r0 = regs[0];

  // primary port (load result) outranks secondary port (address update)
  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (wen_p && wa_p == AW'(i))      regs[i] <= wd_p;
        else if (wen_s && wa_s == AW'(i)) regs[i] <= wd_s;
      end
    end
  end

  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!wen_p && !wen_s) |=> $stable(regs))
    else $error("register changed with no write enabled");
endmodule

// File: rtl/lsu_exec.sv
module lsu_exec
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [15:0]       instr,
  input  logic [DATA_W-1:0] pc_in,
  output logic [DATA_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              illegal
);
  dec_t              dec;
  logic              go;
  logic [DATA_W-1:0] rbase, rdata_src, r0_val, upd_val, ld_val, wd_p;
  logic              wen_p, wen_s;

  lsu_decode u_dec (.instr(instr), .dec(dec));

  lsu_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst(rst),
    .ra_a(dec.base_idx), .ra_b(dec.data_idx),
    .rd_a(rbase), .rd_b(rdata_src), .rd_r0(r0_val),
    .wen_p(wen_p), .wa_p(dec.dst_idx), .wd_p(wd_p),
    .wen_s(wen_s), .wa_s(dec.base_idx), .wd_s(upd_val)
  );

  lsu_agu #(.DATA_W(DATA_W)) u_agu (
    .base(dec.base), .size(dec.size), .disp(dec.disp), .predec(dec.predec),
    .pc(pc_in), .rbase(rbase), .r0(r0_val),
    .addr(mem_addr), .upd(upd_val)
  );

  assign go      = instr_valid && dec.legal;
  assign illegal = instr_valid && !dec.legal;
  assign mem_re  = go && (dec.kind == K_LOAD);
  assign mem_we  = go && (dec.kind == K_STORE);
  assign mem_size = dec.size;

  always_comb begin
    unique case (dec.size)
      SZ_B:    mem_wdata = DATA_W'(rdata_src[7:0]);
      SZ_W:    mem_wdata = DATA_W'(rdata_src[15:0]);
      default: mem_wdata = rdata_src;
    endcase
  end

  always_comb begin
    unique case (dec.size)
      SZ_B:    ld_val = {{(DATA_W-8){mem_rdata[7]}}, mem_rdata[7:0]};
      SZ_W:    ld_val = {{(DATA_W-16){mem_rdata[15]}}, mem_rdata[15:0]};
      default: ld_val = mem_rdata;
    endcase
  end

  always_comb begin
    unique case (dec.kind)
      K_IMM:   wd_p = {{(DATA_W-8){instr[7]}}, instr[7:0]};
      K_COPY:  wd_p = rdata_src;
      default: wd_p = ld_val;
    endcase
  end

  assign wen_p = go && (dec.kind == K_IMM || dec.kind == K_COPY || dec.kind == K_LOAD);
  assign wen_s = go && (dec.predec || dec.postinc);

  p_rw_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re))
    else $error("read and write enabled together");

  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!mem_we && !mem_re && !wen_p && !wen_s))
    else $error("illegal word caused an effect");

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> (!mem_we && !mem_re && !illegal && !wen_p && !wen_s))
    else $error("activity without a valid instruction");

  p_update_kind_r5: assert property (@(posedge clk) disable iff (rst)
    wen_s |-> ((dec.postinc && mem_re) || (dec.predec && mem_we)))
    else $error("address update on a non-updating form");
endmodule

// File: tb/sim_lsu_exec.sv
module sim_lsu_exec;
  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [15:0] instr;
  logic [31:0] pc_in;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        mem_re, mem_we, illegal;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lsu_exec u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr), .pc_in(pc_in),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .illegal(illegal)
  );

  // {req, instr, rdata, re, we, size, addr, wdata, ill}
  localparam int VW = 121;
  localparam int NV = 41;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd1, 16'hE110, 32'h0, 1'b0,1'b0,2'd0, 32'h0, 32'h0, 1'b0},                  // R1 R1=0x10
    {4'd1, 16'hE2FC, 32'h0, 1'b0,1'b0,2'd0, 32'h0, 32'h0, 1'b0},                  // R1 R2=-4
    {4'd1, 16'h2122, 32'h0, 1'b0,1'b1,2'd2, 32'h10, 32'hFFFFFFFC, 1'b0},          // R1 exposes both
    {4'd9, 16'h2120, 32'h0, 1'b0,1'b1,2'd0, 32'h10, 32'h000000FC, 1'b0},          // R9 byte store
    {4'd4, 16'h2125, 32'h0, 1'b0,1'b1,2'd1, 32'h0E, 32'h0000FFFC, 1'b0},          // R4 predec word
    {4'd3, 16'h6310, 32'h12345680, 1'b1,1'b0,2'd0, 32'h0E, 32'h0, 1'b0},          // R3 byte load
    {4'd3, 16'h2132, 32'h0, 1'b0,1'b1,2'd2, 32'h0E, 32'hFFFFFF80, 1'b0},          // R3 sext byte
    {4'd5, 16'h6415, 32'h00007FFF, 1'b1,1'b0,2'd1, 32'h0E, 32'h0, 1'b0},          // R5 postinc word
    {4'd5, 16'h2142, 32'h0, 1'b0,1'b1,2'd2, 32'h10, 32'h00007FFF, 1'b0},          // R5 R1+2, R4
    {4'd5, 16'h6116, 32'h12345678, 1'b1,1'b0,2'd2, 32'h10, 32'h0, 1'b0},          // R5 n==m
    {4'd5, 16'h2212, 32'h0, 1'b0,1'b1,2'd2, 32'hFFFFFFFC, 32'h12345678, 1'b0},    // R5 load wins
    {4'd3, 16'h6523, 32'h0, 1'b0,1'b0,2'd0, 32'h0, 32'h0, 1'b0},                  // R3 copy
    {4'd3, 16'h2152, 32'h0, 1'b0,1'b1,2'd2, 32'h12345678, 32'hFFFFFFFC, 1'b0},    // R3 copy seen
    {4'd6, 16'hE020, 32'h0, 1'b0,1'b0,2'd0, 32'h0, 32'h0, 1'b0},                  // R6 R0=0x20
    {4'd6, 16'hE630, 32'h0, 1'b0,1'b0,2'd0, 32'h0, 32'h0, 1'b0},                  // R6 R6=0x30
    {4'd6, 16'h8063, 32'h0, 1'b0,1'b1,2'd0, 32'h33, 32'h20, 1'b0},                // R6 byte R0
    {4'd6, 16'h8163, 32'h0, 1'b0,1'b1,2'd1, 32'h36, 32'h20, 1'b0},                // R6 word R0
    {4'd7, 16'h1652, 32'h0, 1'b0,1'b1,2'd2, 32'h38, 32'hFFFFFFFC, 1'b0},          // R7 long store
    {4'd7, 16'h5761, 32'hA5A5A5A5, 1'b1,1'b0,2'd2, 32'h34, 32'h0, 1'b0},          // R7 long load
    {4'd7, 16'h2072, 32'h0, 1'b0,1'b1,2'd2, 32'h20, 32'hA5A5A5A5, 1'b0},          // R7 loaded
    {4'd6, 16'h8465, 32'hFFFFFF7F, 1'b1,1'b0,2'd0, 32'h35, 32'h0, 1'b0},          // R6 byte to R0
    {4'd6, 16'h2602, 32'h0, 1'b0,1'b1,2'd2, 32'h30, 32'h0000007F, 1'b0},          // R6 R0 value
    {4'd6, 16'h8562, 32'h55558001, 1'b1,1'b0,2'd1, 32'h34, 32'h0, 1'b0},          // R6 word to R0
    {4'd6, 16'h2602, 32'h0, 1'b0,1'b1,2'd2, 32'h30, 32'hFFFF8001, 1'b0},          // R6 sext word
    {4'd8, 16'hE008, 32'h0, 1'b0,1'b0,2'd0, 32'h0, 32'h0, 1'b0},                  // R8 R0=8
    {4'd8, 16'h0674, 32'h0, 1'b0,1'b1,2'd0, 32'h38, 32'h000000A5, 1'b0},          // R8 byte index
    {4'd8, 16'h0675, 32'h0, 1'b0,1'b1,2'd1, 32'h38, 32'h0000A5A5, 1'b0},          // R8 word index
    {4'd2, 16'h9805, 32'hDEAD9000, 1'b1,1'b0,2'd1, 32'h100A, 32'h0, 1'b0},        // R2 pc word
    {4'd2, 16'hD903, 32'h0BADF00D, 1'b1,1'b0,2'd2, 32'h100C, 32'h0, 1'b0},        // R2 pc long
    {4'd2, 16'h2682, 32'h0, 1'b0,1'b1,2'd2, 32'h30, 32'hFFFF9000, 1'b0},          // R2 R8
    {4'd2, 16'h2692, 32'h0, 1'b0,1'b1,2'd2, 32'h30, 32'h0BADF00D, 1'b0},          // R2 R9
    {4'd4, 16'h2624, 32'h0, 1'b0,1'b1,2'd0, 32'h2F, 32'h000000FC, 1'b0},          // R4 predec byte
    {4'd4, 16'h2626, 32'h0, 1'b0,1'b1,2'd2, 32'h2B, 32'hFFFFFFFC, 1'b0},          // R4 predec long
    {4'd5, 16'h6A64, 32'h000000FF, 1'b1,1'b0,2'd0, 32'h2B, 32'h0, 1'b0},          // R5 postinc byte
    {4'd5, 16'h26A2, 32'h0, 1'b0,1'b1,2'd2, 32'h2C, 32'hFFFFFFFF, 1'b0},          // R5 R6+1, R10
    {4'd10, 16'hFFFF, 32'h0, 1'b0,1'b0,2'd0, 32'h0, 32'h0, 1'b1},                 // R10
    {4'd10, 16'h6667, 32'h0, 1'b0,1'b0,2'd0, 32'h0, 32'h0, 1'b1},                 // R10
    {4'd10, 16'h2127, 32'h0, 1'b0,1'b0,2'd0, 32'h0, 32'h0, 1'b1},                 // R10
    {4'd10, 16'h8263, 32'h0, 1'b0,1'b0,2'd0, 32'h0, 32'h0, 1'b1},                 // R10
    {4'd10, 16'h0676, 32'h0, 1'b0,1'b0,2'd0, 32'h0, 32'h0, 1'b1},                 // R10
    {4'd10, 16'h2662, 32'h0, 1'b0,1'b1,2'd2, 32'h2C, 32'h0000002C, 1'b0}          // R10 R6 kept
  };

  task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [15:0] w, input logic [31:0] rd);
    @(negedge clk);
    instr_valid = v; instr = w; mem_rdata = rd;
    #2;
  endtask

  task automatic expect_port(input int req, input logic re, input logic we, input logic [1:0] sz,
                             input logic [31:0] a, input logic [31:0] wd, input logic il);
    chk("mem_re", req, 32'(mem_re), 32'(re));
    chk("mem_we", req, 32'(mem_we), 32'(we));
    chk("illegal", req, 32'(illegal), 32'(il));
    if (re || we) begin
      chk("mem_size", req, 32'(mem_size), 32'(sz));
      chk("mem_addr", req, mem_addr, a);
    end
    if (we) chk("mem_wdata", req, mem_wdata, wd);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; instr_valid = 1'b0; instr = 16'h0; pc_in = 32'h1000; mem_rdata = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R12: registers start at zero (R1 base, R2 data)
    apply(1'b1, 16'h2122, 32'h0);
    expect_port(12, 1'b0, 1'b1, 2'd2, 32'h0, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      apply(1'b1, v[116:101], v[100:69]);
      expect_port(int'(v[120:117]), v[68], v[67], v[66:65], v[64:33], v[32:1], v[0]);
    end

    // R11: no valid -> no enables even for a store / illegal word
    apply(1'b0, 16'h2122, 32'h0);
    expect_port(11, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0);
    apply(1'b0, 16'hFFFF, 32'h0);
    expect_port(11, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0);
    // R11: a post-increment load held invalid must not touch R1
    apply(1'b0, 16'h6116, 32'hCAFEF00D);
    apply(1'b1, 16'h2212, 32'h0);
    expect_port(11, 1'b0, 1'b1, 2'd2, 32'hFFFFFFFC, 32'h12345678, 1'b0);

    // R12: reset in mid-run clears registers
    @(negedge clk); rst = 1'b1; instr_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    apply(1'b1, 16'h2212, 32'h0);
    expect_port(12, 1'b0, 1'b1, 2'd2, 32'h0, 32'h0, 1'b0);
    apply(1'b1, 16'h26A2, 32'h0);
    expect_port(12, 1'b0, 1'b1, 2'd2, 32'h0, 32'h0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule